// File: doc/BRIEF.md
# Serial DAC Frame Driver

This block sits on the host side of a dual-channel serial digital-to-analog converter. A client hands it a conversion code and a channel mask through a valid/ready handshake. The block then selects the converter, clocks out a padded frame with the most significant bit first, deselects it, and pulses the active-low load strobe of each channel named in the mask. When the load hold time has passed, it raises a one-cycle completion pulse and accepts the next command.

Every interface minimum is a parameter given in system clock cycles. These minimums are the select lead, the clock high and low phases, the load setup, the strobe width and the load hold. The serial clock idles low. The receiver samples data on the rising clock edge. Data changes only on falling edges, so the clock-high phase provides the data hold time and the clock-low phase provides the data setup time.

Top module: `sdac_frame_driver`

## Requirements
- R1: After reset the driver shows select high, serial clock low, both strobes high, ready high, busy low and done low.
- R2: A command is taken only on a cycle where valid and ready are both high. Ready is low (and busy high) from the following cycle until the done pulse has ended. While valid is low and the driver is idle, select stays high.
- R3: Each frame has FRAME_W (16) rising serial clock edges. The first FRAME_W-CODE_W (4) bits are sent as zeros, and the code follows, most significant bit first.
- R4: The serial clock is high only while select is low. Every high phase lasts exactly T_HIGH cycles, every low phase between two rising edges lasts exactly T_LOW cycles, and data never changes while the clock is high.
- R5: Select falls exactly T_LEAD cycles before the first rising edge, with the first data bit already present. Select rises on the cycle the clock falls after the last bit.
- R6: Both load strobes stay high whenever select is low.
- R7: Strobe bit 0 follows mask bit 0 and strobe bit 1 follows mask bit 1. All selected strobes fall together T_LDSET cycles after select rises and stay low for exactly T_LDW cycles.
- R8: With a zero mask the frame is still sent and no strobe moves. Done then comes T_LDSET+T_LDW+T_LDHOLD cycles after select rises.
- R9: Done is high for exactly one cycle, T_LDHOLD cycles after the strobes return high, and ready is high on the next cycle.
- R10: A command offered while the driver is busy is not taken and does not change the frame in flight. If it is still offered once ready returns, it is taken then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Driver idle, command can be taken |
| cmd_code | input | CODE_W (12) | Conversion code to send |
| cmd_chan | input | CHAN_N (2) | Channel mask, bit 0 channel A, bit 1 channel B |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| dac_cs_n | output | 1 | Active-low converter select |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdi | output | 1 | Serial data, changes on falling edges |
| dac_ld_n | output | CHAN_N (2) | Active-low load strobes, one per channel |

## Verification
The two events that can share a cycle are the end of a transfer and the offer of a new command. In the same cycle, done pulses and the client may already be holding valid high with a different code and mask. The bench raises valid partway through a frame and keeps it high across the done pulse. It then judges two things: the frame in flight carries only the first code and strobe pattern, and the second command starts cleanly on the cycle after ready returns, with its own bits, timing and strobes.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } sdac_state_e;

  function automatic int tmax6(input int a, input int b, input int c,
                               input int d, input int e, input int f);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    if (f > m) m = f;
    return m;
  endfunction

endpackage

// File: rtl/sdac_timer.sv
module sdac_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int CODE_W  = 12,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              shift,
  output logic              sdo,
  output logic              last
);

  localparam int PAD_W = FRAME_W - CODE_W;
  localparam int IDX_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]   idx_q, idx_d;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load) begin
      sh_d  = {{PAD_W{1'b0}}, code};
      idx_d = '0;
    end else if (shift) begin
      sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign sdo  = sh_q[FRAME_W-1];
  assign last = (idx_q == IDX_W'(FRAME_W - 1));

  // R3: never shift beyond the final frame bit
  a_r3_no_shift_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last);

endmodule

// File: rtl/sdac_frame_driver.sv
module sdac_frame_driver
  import sdac_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int FRAME_W  = 16,
  parameter int CHAN_N   = 2,
  parameter int T_LEAD   = 2,
  parameter int T_HIGH   = 3,
  parameter int T_LOW    = 3,
  parameter int T_LDSET  = 2,
  parameter int T_LDW    = 2,
  parameter int T_LDHOLD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [CHAN_N-1:0] cmd_chan,
  output logic              busy,
  output logic              done,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdi,
  output logic [CHAN_N-1:0] dac_ld_n
);

  localparam int T_MAX = tmax6(T_LEAD, T_HIGH, T_LOW, T_LDSET, T_LDW, T_LDHOLD);
  localparam int TMR_W = $clog2(T_MAX + 1);

  sdac_state_e       state_q, state_d;
  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              take, shift_en, last_bit;
  logic [CHAN_N-1:0] chan_q, chan_d;
  logic              cs_n_q, cs_n_d, sclk_q, sclk_d;
  logic              ready_q, ready_d, done_q, done_d;

  function automatic logic [TMR_W-1:0] dur_of(input sdac_state_e s);
    case (s)
      ST_LEAD:   return TMR_W'(T_LEAD - 1);
      ST_HIGH:   return TMR_W'(T_HIGH - 1);
      ST_LOW:    return TMR_W'(T_LOW - 1);
      ST_TAIL:   return TMR_W'(T_LDSET - 1);
      ST_STROBE: return TMR_W'(T_LDW - 1);
      ST_HOLD:   return TMR_W'(T_LDHOLD - 1);
      default:   return '0;
    endcase
  endfunction

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (cmd_valid) state_d = ST_LEAD;
      ST_LEAD:   if (tmr_exp)   state_d = ST_HIGH;
      ST_HIGH:   if (tmr_exp)   state_d = last_bit ? ST_TAIL : ST_LOW;
      ST_LOW:    if (tmr_exp)   state_d = ST_HIGH;
      ST_TAIL:   if (tmr_exp)   state_d = ST_STROBE;
      ST_STROBE: if (tmr_exp)   state_d = ST_HOLD;
      ST_HOLD:   if (tmr_exp)   state_d = ST_DONE;
      ST_DONE:                  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  assign take     = (state_q == ST_IDLE) && cmd_valid;
  assign shift_en = (state_q == ST_HIGH) && (state_d == ST_LOW);
  assign tmr_load = (state_d != state_q);
  assign tmr_val  = dur_of(state_d);
  assign chan_d   = take ? cmd_chan : chan_q;

  // registered pin values derived from the next state
  always_comb begin
    cs_n_d  = !((state_d == ST_LEAD) || (state_d == ST_HIGH) || (state_d == ST_LOW));
    sclk_d  = (state_d == ST_HIGH);
    ready_d = (state_d == ST_IDLE);
    done_d  = (state_d == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      ready_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      ready_q <= ready_d;
      done_q  <= done_d;
    end
  end

  for (genvar g = 0; g < CHAN_N; g++) begin : g_strobe
    logic ld_q, ld_d;
    assign ld_d = !((state_d == ST_STROBE) && chan_q[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ld_q <= 1'b1;
      else        ld_q <= ld_d;
    end
    assign dac_ld_n[g] = ld_q;
  end

  sdac_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  sdac_shifter #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take),
    .code  (cmd_code),
    .shift (shift_en),
    .sdo   (dac_sdi),
    .last  (last_bit)
  );

  assign cmd_ready = ready_q;
  assign busy      = !ready_q;
  assign done      = done_q;
  assign dac_cs_n  = cs_n_q;
  assign dac_sclk  = sclk_q;

  // R6: strobes idle while the converter is selected
  a_r6_ld_high_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> (dac_ld_n == '1));

  // R4: clock pulses only inside a selected window
  a_r4_sclk_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sclk |-> !dac_cs_n);

  // R4: data holds through the whole high phase
  a_r4_sdi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdi));

  // R2: a taken command closes the handshake on the next cycle
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R9: done is a single cycle and is followed by ready
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));

  // R7: only masked channels are strobed
  a_r7_strobe_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_ld_n != '1) |-> (&(dac_ld_n | chan_q)));

endmodule

// File: tb/sdac_frame_driver_tb.sv
module sdac_frame_driver_tb;

  localparam int CLK_PERIOD = 10;
  localparam int T_LEAD   = 2;
  localparam int T_HIGH   = 3;
  localparam int T_LOW    = 3;
  localparam int T_LDSET  = 2;
  localparam int T_LDW    = 2;
  localparam int T_LDHOLD = 3;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready, busy, done;
  logic [11:0] cmd_code;
  logic [1:0]  cmd_chan;
  logic        dac_cs_n, dac_sclk, dac_sdi;
  logic [1:0]  dac_ld_n;

  int total = 0;
  int bad   = 0;

  sdac_frame_driver #(
    .CODE_W(12), .FRAME_W(16), .CHAN_N(2),
    .T_LEAD(T_LEAD), .T_HIGH(T_HIGH), .T_LOW(T_LOW),
    .T_LDSET(T_LDSET), .T_LDW(T_LDW), .T_LDHOLD(T_LDHOLD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_chan(cmd_chan),
    .busy(busy), .done(done),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi),
    .dac_ld_n(dac_ld_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // runs one transfer from the first selected cycle to the cycle after done
  task automatic capture(input logic [11:0] code, input logic [1:0] mask,
                         input bit intrude, input logic [11:0] icode,
                         input logic [1:0] imask);
    logic [15:0] bits = '0;
    logic [1:0]  ld_seen = 2'b11;
    logic        prev_sclk = 1'b0, prev_sdi = 1'b0;
    int rises = 0, lead = 0, hi_run = 0, lo_run = 0;
    int hi_bad = 0, lo_bad = 0, sdi_bad = 0, ld_in_cs = 0, rdy_bad = 0;
    int ldlow = 0, pre = 0, post = 0, tail = 0, done_cnt = 0;
    bit finished = 0;
    for (int i = 0; i < 2000 && !finished; i++) begin
      if (done) begin
        done_cnt++;
        finished = 1;
      end else begin
        if (cmd_ready || !busy) rdy_bad++;
        if (!dac_cs_n && dac_ld_n != 2'b11) ld_in_cs++;
        if (!dac_cs_n && !dac_sclk && rises == 0) lead++;
        if (dac_sclk && !prev_sclk) begin
          if (rises > 0 && lo_run != T_LOW) lo_bad++;
          rises++;
          bits = {bits[14:0], dac_sdi};
          hi_run = 1;
        end else if (dac_sclk) begin
          hi_run++;
          if (dac_sdi != prev_sdi) sdi_bad++;
        end else if (prev_sclk) begin
          if (hi_run != T_HIGH) hi_bad++;
          lo_run = 1;
        end else if (!dac_cs_n && rises > 0) begin
          lo_run++;
        end
        if (dac_cs_n && rises > 0) begin
          tail++;
          if (dac_ld_n != 2'b11) begin
            ldlow++;
            ld_seen = dac_ld_n;
          end else if (ldlow == 0) pre++;
          else post++;
        end
        prev_sclk = dac_sclk;
        prev_sdi  = dac_sdi;
      end
      @(negedge clk);
      if (intrude && i == 20) begin
        cmd_valid = 1'b1;
        cmd_code  = icode;
        cmd_chan  = imask;
      end
    end
    chk(finished, "R9 done reached", finished, 1);
    chk(cmd_ready && !done, "R9 ready after done", {cmd_ready, done}, 2'b10);
    chk(done_cnt == 1, "R9 done count", done_cnt, 1);
    chk(rdy_bad == 0, "R2 ready low while busy", rdy_bad, 0);
    chk(rises == 16, "R3 rising edges", rises, 16);
    chk(bits == {4'b0000, code}, "R3 frame bits", bits, {4'b0000, code});
    chk(lead == T_LEAD, "R5 select lead", lead, T_LEAD);
    chk(hi_bad == 0, "R4 high phase width", hi_bad, 0);
    chk(lo_bad == 0, "R4 low phase width", lo_bad, 0);
    chk(sdi_bad == 0, "R4 data stable while high", sdi_bad, 0);
    chk(ld_in_cs == 0, "R6 strobes high while selected", ld_in_cs, 0);
    if (mask != 2'b00) begin
      chk(ld_seen == ~mask, "R7 strobe pattern", ld_seen, ~mask);
      chk(ldlow == T_LDW, "R7 strobe width", ldlow, T_LDW);
      chk(pre == T_LDSET, "R7 load setup", pre, T_LDSET);
      chk(post == T_LDHOLD, "R9 load hold", post, T_LDHOLD);
    end else begin
      chk(ldlow == 0, "R8 no strobe for zero mask", ldlow, 0);
      chk(tail == T_LDSET + T_LDW + T_LDHOLD, "R8 tail length", tail,
          T_LDSET + T_LDW + T_LDHOLD);
    end
  endtask

  task automatic send(input logic [11:0] code, input logic [1:0] mask);
    chk(cmd_ready, "R2 ready before offer", cmd_ready, 1);
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_chan  = mask;
    @(negedge clk);
    cmd_valid = 1'b0;
    capture(code, mask, 1'b0, 12'h000, 2'b00);
  endtask

  task automatic t_reset;
    chk(dac_cs_n && !dac_sclk && dac_ld_n == 2'b11, "R1 pins at reset",
        {dac_cs_n, dac_sclk, dac_ld_n}, 4'b1011);
    chk(cmd_ready && !busy && !done, "R1 handshake at reset",
        {cmd_ready, busy, done}, 3'b100);
  endtask

  task automatic t_idle_quiet;
    int moved = 0;
    for (int i = 0; i < 10; i++) begin
      if (!dac_cs_n || dac_sclk || !cmd_ready) moved++;
      @(negedge clk);
    end
    chk(moved == 0, "R2 idle without valid", moved, 0);
  endtask

  task automatic t_chan_a;   send(12'hA5C, 2'b01); endtask
  task automatic t_chan_b;   send(12'h3F0, 2'b10); endtask
  task automatic t_both;     send(12'hFFF, 2'b11); endtask
  task automatic t_zero_mask; send(12'h001, 2'b00); endtask

  task automatic t_busy_offer;
    chk(cmd_ready, "R10 ready before first", cmd_ready, 1);
    cmd_valid = 1'b1;
    cmd_code  = 12'h800;
    cmd_chan  = 2'b01;
    @(negedge clk);
    cmd_valid = 1'b0;
    capture(12'h800, 2'b01, 1'b1, 12'h123, 2'b10);
    chk(cmd_valid, "R10 offer still pending", cmd_valid, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!dac_cs_n && !cmd_ready, "R10 pending offer taken", {dac_cs_n, cmd_ready}, 2'b00);
    capture(12'h123, 2'b10, 1'b0, 12'h000, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_code  = '0;
    cmd_chan  = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_idle_quiet();
    t_chan_a();
    t_chan_b();
    t_both();
    t_zero_mask();
    t_busy_offer();
    t_idle_quiet();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule